// File: doc/BRIEF.md
# Trap Entry Controller

This block takes a hart into a trap at machine or supervisor level. A one-cycle strobe delivers a trap event: an interrupt flag, a cause number, the faulting address and the PC of the instruction that trapped. On that clock edge the block selects the target level from two delegation masks, one for interrupts and one for synchronous exceptions. It saves the old enable state and the old privilege in the status fields of that level and writes the level's cause, exception-PC and fault-value registers. It also computes the redirect PC from the level's vector register and switches the current privilege.

The block runs as a three-state machine whose state is the current privilege. The states are USER (code 0), SUPER (code 1) and MACHINE (code 3). There are three kinds of transition. TRAP_TO_SUPER is taken from USER or SUPER when the delegation bit of the cause is set. TRAP_TO_MACHINE is taken from every state whenever a trap is not delegated, and always from MACHINE. LOAD moves to any legal level given on the load port, which the surrounding core drives when it returns from a trap or writes the enables. The delegation masks and the vector bases come from the surrounding CSR file as inputs.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the privilege is MACHINE (code 3), every status bit, cause, exception-PC, fault-value and redirect-PC register is zero, and the redirect flag is low.
- R2: A trap taken in USER or SUPER goes to SUPER when the cause's delegation bit is set, and otherwise to MACHINE. A trap taken in MACHINE always stays in MACHINE.
- R3: An interrupt looks up bit `cause` of the interrupt delegation mask. A synchronous exception looks up bit `cause` of the exception delegation mask.
- R4: On entry to MACHINE, the machine previous-enable bit takes the old machine enable, the machine previous-privilege field takes the old privilege, and the machine enable is cleared. The supervisor status bits are unchanged.
- R5: On entry to SUPER, the supervisor previous-enable bit takes the old supervisor enable, the one-bit supervisor previous-privilege takes bit 0 of the old privilege, and the supervisor enable is cleared. The machine status bits are unchanged.
- R6: The target level's cause register receives the cause number in its low bits and the interrupt flag in its most significant bit. All other bits are zero. The other level's cause register is unchanged.
- R7: The target level's exception-PC register receives the trapping PC.
- R8: The target level's fault-value register receives the trap address for the synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It receives zero for every other synchronous cause and for every interrupt.
- R9: A synchronous cause of 8, 9 or 11 is rewritten to 8 from USER, 9 from SUPER and 11 from MACHINE. The rewritten value is used both for delegation and for the cause register.
- R10: The redirect PC is the target level's vector base with bits [1:0] cleared. When the trap is an interrupt and the vector's bits [1:0] equal 1, four times the cause is added to that base.
- R11: The redirect flag is high for exactly the cycle after each trap edge, with the redirect PC and the new privilege already valid in that cycle.
- R12: A load request with no trap sets the privilege and the machine and supervisor enables from the load port. When a trap and a load arrive on the same edge, the trap wins and the load is discarded.
- R13: A load request carrying the reserved privilege code 2 leaves the privilege unchanged. The enables from that request are still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | One-cycle trap event strobe |
| trap_is_irq | input | 1 | Event is an interrupt |
| trap_cause | input | CAUSE_W | Raw cause number |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| m_vec | input | XLEN | Machine vector base and mode |
| s_vec | input | XLEN | Supervisor vector base and mode |
| ctl_load | input | 1 | Load privilege and enables |
| ctl_priv | input | 2 | Privilege to load |
| ctl_mie | input | 1 | Machine enable to load |
| ctl_sie | input | 1 | Supervisor enable to load |
| priv | output | 2 | Current privilege |
| redirect | output | 1 | Redirect pulse after a trap |
| redirect_pc | output | XLEN | Handler PC |
| st_mie | output | 1 | Machine interrupt enable |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_mpie | output | 1 | Machine previous enable |
| st_spie | output | 1 | Supervisor previous enable |
| st_mpp | output | 2 | Machine previous privilege |
| st_spp | output | 1 | Supervisor previous privilege |
| m_cause | output | XLEN | Machine cause register |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine fault value |
| s_cause | output | XLEN | Supervisor cause register |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor fault value |

## Verification
A wrong privilege state shows on the next trap, because the delegation decision, the saved previous-privilege field and any rewritten environment-call cause all depend on it. It also shows directly on the `priv` port one cycle after the edge that corrupted it. Corrupted enable bits surface in the previous-enable field of the following trap to that level. A wrong cause, exception-PC, fault-value or redirect-PC is visible in the cycle right after the trap edge. Random traps from random privileges under random masks, checked against a bench model, expose a divergence within one trap of it happening.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    // vector mode value that enables per-cause interrupt dispatch
    localparam logic [1:0] VEC_MODE_TABLE = 2'b01;

    // synchronous causes whose fault value carries the trap address
    localparam logic [15:0] ADDR_CAUSE_MASK = 16'hB0F3;

endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  priv_e               cur_priv,
    input  logic                is_irq,
    input  logic [CAUSE_W-1:0]  raw_cause,
    input  logic [XLEN-1:0]     fault_addr,
    input  logic [XLEN-1:0]     exc_deleg,
    input  logic [XLEN-1:0]     irq_deleg,
    output logic [CAUSE_W-1:0]  eff_cause,
    output logic                deleg_bit,
    output logic [XLEN-1:0]     tval_value
);
    localparam int NCAUSE = 1 << CAUSE_W;
    localparam logic [NCAUSE-1:0] ADDR_MASK = NCAUSE'(ADDR_CAUSE_MASK);

    logic is_ecall;
    logic carries_addr;

    always_comb begin
        is_ecall = !is_irq &&
                   (raw_cause == CAUSE_W'(8) || raw_cause == CAUSE_W'(9) ||
                    raw_cause == CAUSE_W'(11));
        // R9: environment call renumbered by calling privilege
        eff_cause = is_ecall ? (CAUSE_W'(8) | CAUSE_W'(cur_priv)) : raw_cause;
        // R3: mask chosen by the kind of trap
        deleg_bit = is_irq ? irq_deleg[eff_cause] : exc_deleg[eff_cause];
        carries_addr = !is_irq && ADDR_MASK[eff_cause];
        tval_value = carries_addr ? fault_addr : '0;
    end

    // R8: an interrupt never reports an address
    always_comb begin
        if (is_irq) begin
            a_r8_irq_no_addr: assert (tval_value == '0);
        end
    end

endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic [XLEN-1:0]    vec_reg,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target_pc
);
    localparam int PAD_W = XLEN - CAUSE_W - 2;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic            use_table;

    always_comb begin
        base      = {vec_reg[XLEN-1:2], 2'b00};
        use_table = is_irq && (vec_reg[1:0] == VEC_MODE_TABLE);
        offset    = use_table ? {{PAD_W{1'b0}}, cause, 2'b00} : '0;
        target_pc = base + offset;
    end

    // R10: exceptions always land on the aligned base
    always_comb begin
        if (!is_irq) begin
            a_r10_sync_base: assert (target_pc == {vec_reg[XLEN-1:2], 2'b00});
        end
    end

endmodule

// File: rtl/trap_level_bank.sv
module trap_level_bank #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] cause_in,
    input  logic [XLEN-1:0] epc_in,
    input  logic [XLEN-1:0] tval_in,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] tval_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
            tval_q  <= '0;
        end else if (wr_en) begin
            cause_q <= cause_in;
            epc_q   <= epc_in;
            tval_q  <= tval_in;
        end
    end

    // R7: a written bank holds the presented PC afterwards
    a_r7_epc_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> epc_q == $past(epc_in));

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [XLEN-1:0]    exc_deleg,
    input  logic [XLEN-1:0]    irq_deleg,
    input  logic [XLEN-1:0]    m_vec,
    input  logic [XLEN-1:0]    s_vec,
    input  logic               ctl_load,
    input  logic [1:0]         ctl_priv,
    input  logic               ctl_mie,
    input  logic               ctl_sie,
    output logic [1:0]         priv,
    output logic               redirect,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               st_mie,
    output logic               st_sie,
    output logic               st_mpie,
    output logic               st_spie,
    output logic [1:0]         st_mpp,
    output logic               st_spp,
    output logic [XLEN-1:0]    m_cause,
    output logic [XLEN-1:0]    m_epc,
    output logic [XLEN-1:0]    m_tval,
    output logic [XLEN-1:0]    s_cause,
    output logic [XLEN-1:0]    s_epc,
    output logic [XLEN-1:0]    s_tval
);
    localparam int CAUSE_PAD = XLEN - 1 - CAUSE_W;

    priv_e              state_q, state_d;
    logic [CAUSE_W-1:0] eff_cause;
    logic               deleg_bit;
    logic [XLEN-1:0]    tval_value;
    logic [XLEN-1:0]    vec_sel;
    logic [XLEN-1:0]    vec_pc;
    logic [XLEN-1:0]    cause_word;
    logic               take_s, take_m;
    logic               load_legal;

    trap_target_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_sel (
        .cur_priv   (state_q),
        .is_irq     (trap_is_irq),
        .raw_cause  (trap_cause),
        .fault_addr (trap_addr),
        .exc_deleg  (exc_deleg),
        .irq_deleg  (irq_deleg),
        .eff_cause  (eff_cause),
        .deleg_bit  (deleg_bit),
        .tval_value (tval_value)
    );

    // next state: privilege machine
    always_comb begin
        state_d    = state_q;
        load_legal = (ctl_priv != 2'b10);
        unique case (state_q)
            PRIV_U, PRIV_S: begin
                if (trap_valid) begin
                    state_d = deleg_bit ? PRIV_S : PRIV_M;   // TRAP_TO_SUPER / TRAP_TO_MACHINE
                end else if (ctl_load && load_legal) begin
                    state_d = priv_e'(ctl_priv);             // LOAD
                end
            end
            PRIV_M: begin
                if (trap_valid) begin
                    state_d = PRIV_M;                        // TRAP_TO_MACHINE
                end else if (ctl_load && load_legal) begin
                    state_d = priv_e'(ctl_priv);             // LOAD
                end
            end
            default: state_d = PRIV_M;
        endcase
    end

    always_comb begin
        take_s     = trap_valid && (state_d == PRIV_S);
        take_m     = trap_valid && !take_s;
        vec_sel    = take_s ? s_vec : m_vec;
        cause_word = {trap_is_irq, {CAUSE_PAD{1'b0}}, eff_cause};
    end

    trap_vec_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
        .vec_reg   (vec_sel),
        .is_irq    (trap_is_irq),
        .cause     (eff_cause),
        .target_pc (vec_pc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PRIV_M;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers: status stack and redirect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_mie      <= 1'b0;
            st_sie      <= 1'b0;
            st_mpie     <= 1'b0;
            st_spie     <= 1'b0;
            st_mpp      <= 2'b00;
            st_spp      <= 1'b0;
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else if (trap_valid) begin
            redirect    <= 1'b1;
            redirect_pc <= vec_pc;
            if (take_s) begin
                st_spie <= st_sie;
                st_sie  <= 1'b0;
                st_spp  <= state_q[0];
            end else begin
                st_mpie <= st_mie;
                st_mie  <= 1'b0;
                st_mpp  <= state_q;
            end
        end else begin
            redirect <= 1'b0;
            if (ctl_load) begin
                st_mie <= ctl_mie;
                st_sie <= ctl_sie;
            end
        end
    end

    trap_level_bank #(.XLEN(XLEN)) u_mbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (take_m),
        .cause_in (cause_word),
        .epc_in   (trap_pc),
        .tval_in  (tval_value),
        .cause_q  (m_cause),
        .epc_q    (m_epc),
        .tval_q   (m_tval)
    );

    trap_level_bank #(.XLEN(XLEN)) u_sbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (take_s),
        .cause_in (cause_word),
        .epc_in   (trap_pc),
        .tval_in  (tval_value),
        .cause_q  (s_cause),
        .epc_q    (s_epc),
        .tval_q   (s_tval)
    );

    assign priv = state_q;

    a_r2_machine_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && state_q == PRIV_M) |=> state_q == PRIV_M);

    a_r2_delegated_to_s: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && state_q != PRIV_M && deleg_bit) |=> state_q == PRIV_S);

    a_r4_machine_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && (state_q == PRIV_M || !deleg_bit))
        |=> (!st_mie && st_mpie == $past(st_mie) && st_mpp == $past(state_q)
             && $stable(st_sie)));

    a_r5_super_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && state_q != PRIV_M && deleg_bit)
        |=> (!st_sie && st_spie == $past(st_sie) && $stable(st_mie)));

    a_r11_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redirect);

    a_r11_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !redirect);

    a_r13_legal_priv: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b10);

endmodule

// File: tb/trap_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb_top;
    localparam int XLEN = 32;
    localparam int CW   = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic trap_valid, trap_is_irq;
    logic [CW-1:0] trap_cause;
    logic [XLEN-1:0] trap_addr, trap_pc, exc_deleg, irq_deleg, m_vec, s_vec;
    logic ctl_load, ctl_mie, ctl_sie;
    logic [1:0] ctl_priv;
    logic [1:0] priv;
    logic redirect;
    logic [XLEN-1:0] redirect_pc;
    logic st_mie, st_sie, st_mpie, st_spie, st_spp;
    logic [1:0] st_mpp;
    logic [XLEN-1:0] m_cause, m_epc, m_tval, s_cause, s_epc, s_tval;

    trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) dut_i (.*);

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    logic [1:0] e_priv;
    logic e_mie, e_sie, e_mpie, e_spie, e_spp;
    logic [1:0] e_mpp;
    logic [XLEN-1:0] e_mcause, e_mepc, e_mtval, e_scause, e_sepc, e_stval, e_pc;

    function automatic logic [CW-1:0] f_eff(input logic irq, input logic [CW-1:0] c,
                                             input logic [1:0] p);
        if (!irq && (c == 5'd8 || c == 5'd9 || c == 5'd11)) return 5'd8 + {3'b0, p};
        return c;
    endfunction

    function automatic logic f_has_addr(input logic [CW-1:0] c);
        case (c)
            5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] f_vec(input logic [XLEN-1:0] v, input logic irq,
                                              input logic [CW-1:0] c);
        logic [XLEN-1:0] b;
        b = v & ~32'd3;
        if (irq && v[1:0] == 2'b01) return b + 32'(c) * 4;
        return b;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "priv", 32'(priv), 32'(e_priv));
        check(req, "mie", 32'(st_mie), 32'(e_mie));
        check(req, "sie", 32'(st_sie), 32'(e_sie));
        check(req, "mpie", 32'(st_mpie), 32'(e_mpie));
        check(req, "spie", 32'(st_spie), 32'(e_spie));
        check(req, "mpp", 32'(st_mpp), 32'(e_mpp));
        check(req, "spp", 32'(st_spp), 32'(e_spp));
        check(req, "m_cause", m_cause, e_mcause);
        check(req, "m_epc", m_epc, e_mepc);
        check(req, "m_tval", m_tval, e_mtval);
        check(req, "s_cause", s_cause, e_scause);
        check(req, "s_epc", s_epc, e_sepc);
        check(req, "s_tval", s_tval, e_stval);
    endtask

    task automatic take_trap(input string req, input logic irq, input logic [CW-1:0] c,
                             input logic [XLEN-1:0] addr, input logic [XLEN-1:0] pc);
        logic [CW-1:0] ec;
        logic dbit, to_s;
        logic [XLEN-1:0] cw, tv, v;
        @(negedge clk);
        trap_valid = 1'b1; trap_is_irq = irq; trap_cause = c;
        trap_addr = addr; trap_pc = pc;
        ec   = f_eff(irq, c, e_priv);
        dbit = irq ? irq_deleg[ec] : exc_deleg[ec];
        to_s = (e_priv != 2'b11) && dbit;
        cw   = {irq, 26'b0, ec};
        tv   = (!irq && f_has_addr(ec)) ? addr : '0;
        if (to_s) begin
            e_spie = e_sie; e_sie = 1'b0; e_spp = e_priv[0];
            e_scause = cw; e_sepc = pc; e_stval = tv; v = s_vec; e_priv = 2'b01;
        end else begin
            e_mpie = e_mie; e_mie = 1'b0; e_mpp = e_priv;
            e_mcause = cw; e_mepc = pc; e_mtval = tv; v = m_vec; e_priv = 2'b11;
        end
        e_pc = f_vec(v, irq, ec);
        @(posedge clk); #1;
        trap_valid = 1'b0; ctl_load = 1'b0;
        check("R11", "redirect high", 32'(redirect), 32'd1);
        check("R10", "redirect_pc", redirect_pc, e_pc);
        check_all(req);
        @(posedge clk); #1;
        check("R11", "redirect low", 32'(redirect), 32'd0);
    endtask

    task automatic load_ctl(input string req, input logic [1:0] p, input logic mi,
                            input logic si);
        @(negedge clk);
        ctl_load = 1'b1; ctl_priv = p; ctl_mie = mi; ctl_sie = si;
        if (p != 2'b10) e_priv = p;
        e_mie = mi; e_sie = si;
        @(posedge clk); #1;
        ctl_load = 1'b0;
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd7;
        void'($urandom(seed));
        rst_n = 1'b0; trap_valid = 1'b0; trap_is_irq = 1'b0; trap_cause = '0;
        trap_addr = '0; trap_pc = '0; exc_deleg = '0; irq_deleg = '0;
        m_vec = 32'h8000_0000; s_vec = 32'h4000_0000;
        ctl_load = 1'b0; ctl_priv = 2'b11; ctl_mie = 1'b0; ctl_sie = 1'b0;
        e_priv = 2'b11; e_mie = 0; e_sie = 0; e_mpie = 0; e_spie = 0; e_spp = 0;
        e_mpp = 0; e_mcause = 0; e_mepc = 0; e_mtval = 0; e_scause = 0; e_sepc = 0;
        e_stval = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        check_all("R1");
        check("R1", "redirect", 32'(redirect), 32'd0);
        check("R1", "redirect_pc", redirect_pc, 32'd0);

        // R9: ecall from M becomes 11
        load_ctl("R12", 2'b11, 1'b1, 1'b1);
        take_trap("R9", 1'b0, 5'd8, 32'h1234, 32'h100);
        // R9 / R5: ecall from S, delegated, becomes 9
        exc_deleg = 32'h0000_0200;
        load_ctl("R12", 2'b01, 1'b1, 1'b1);
        take_trap("R5", 1'b0, 5'd11, 32'h55, 32'h200);
        // R4 / R2: ecall from U not delegated (bit 8 clear) -> M, 8
        load_ctl("R12", 2'b00, 1'b1, 1'b0);
        take_trap("R4", 1'b0, 5'd9, 32'h66, 32'h300);
        // R2: delegated cause from M stays in M
        exc_deleg = 32'hFFFF_FFFF;
        take_trap("R2", 1'b0, 5'd2, 32'h77, 32'h310);
        // R10: vectored interrupt dispatch
        exc_deleg = '0; m_vec = 32'h1000_0001;
        load_ctl("R12", 2'b00, 1'b1, 1'b1);
        take_trap("R10", 1'b1, 5'd7, 32'hABC, 32'h400);
        check("R10", "vectored pc", redirect_pc, 32'h1000_001C);
        m_vec = 32'h1000_0003;
        take_trap("R10", 1'b1, 5'd7, 32'hABC, 32'h404);
        check("R10", "mode 3 base", redirect_pc, 32'h1000_0000);
        m_vec = 32'h1000_0001;
        take_trap("R10", 1'b0, 5'd2, 32'hABC, 32'h408);
        // R3: interrupt vs exception mask, R6 interrupt cause MSB
        irq_deleg = 32'h0000_0020; exc_deleg = '0; s_vec = 32'h4000_0101;
        load_ctl("R12", 2'b01, 1'b0, 1'b1);
        take_trap("R6", 1'b1, 5'd5, 32'hDEAD, 32'h500);
        check("R3", "irq to S", 32'(priv), 32'd1);
        check("R6", "s_cause msb", s_cause, 32'h8000_0005);
        take_trap("R3", 1'b0, 5'd5, 32'hBEEF, 32'h504);
        check("R8", "access fault tval", m_tval, 32'hBEEF);
        // R8: page fault carries address, cause 2 does not
        take_trap("R8", 1'b0, 5'd13, 32'hF00D, 32'h600);
        take_trap("R8", 1'b0, 5'd2, 32'hF00D, 32'h604);
        check("R8", "no-address tval", m_tval, 32'd0);
        // R13: reserved privilege code ignored
        load_ctl("R12", 2'b01, 1'b0, 1'b0);
        load_ctl("R13", 2'b10, 1'b1, 1'b0);
        check("R13", "priv unchanged", 32'(priv), 32'd1);
        // R12: trap wins over simultaneous load
        ctl_load = 1'b1; ctl_priv = 2'b00; ctl_mie = 1'b1; ctl_sie = 1'b1;
        take_trap("R12", 1'b0, 5'd3, 32'h0, 32'h700);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [1:0] p;
            p = 2'($urandom_range(0, 2));
            if (p == 2'b10) p = 2'b11;
            exc_deleg = $urandom; irq_deleg = $urandom;
            m_vec = $urandom; s_vec = $urandom;
            load_ctl("R12", p, 1'($urandom), 1'($urandom));
            take_trap("R7", 1'($urandom), 5'($urandom_range(0, 15)), $urandom, $urandom);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule